// File: doc/BRIEF.md
# Sample Lane Serializer with Programmable Output Resolution

This block sits between the sample path of a dual-channel data converter and the output pads. Once per sample period it captures one sample per channel, either a 16-bit word from the direct or filtered path or a 20-bit word from the channel-averaging path. It reformats each sample to a programmable resolution of 14, 16, 18 or 20 bits, then shifts the result out MSB first on one of three lane arrangements:
- dual-lane: two lanes per channel;
- single-lane: one lane per channel;
- shared-lane: both channels one after the other on a single lane.

The block runs from a clock at the lane bit rate, so one bit leaves each lane per clock. It produces a bit clock at half the lane bit rate, for double-edge capture by the receiver. It also produces a frame marker that is high for the first half of each frame. The `smp_take` output tells the sample source in which cycle its next sample pair is captured.

Resolution, lane arrangement and averaging source come in as static configuration inputs. A change is adopted only at a frame boundary, so a partial word is never sent. A request whose lane bit count would exceed the lane rate limit is reported as invalid and is not adopted.

Top module: `smp_lane_serializer`

## Requirements
- R1: After reset the active configuration is 18-bit, dual-lane, non-averaging, whatever the configuration inputs hold. During reset `smp_take` is 1 and `frm_clk`, `bit_clk`, `lane_a` and `lane_b` are 0. The first frame after reset uses this default.
- R2: Resolution code `cfg_res` = 0 selects 14 bits, 1 selects 16, 2 selects 18 and 3 selects 20. At 14 bits the two lowest bits of a 16-bit sample are dropped without rounding.
- R3: With `cfg_avg` = 0, at 16, 18 or 20 bits the 16-bit sample forms the top of the word and every bit below it is sent as 0.
- R4: With `cfg_avg` = 1 the 20-bit averaged sample is the source. At 20 bits every bit carries sample data; at lower resolutions its low bits are dropped.
- R5: Lane bits per sample (the sample period in clocks) are resolution/2 for dual-lane (`cfg_lane` = 0), resolution for single-lane (`cfg_lane` = 1) and 2×resolution for shared-lane (`cfg_lane` = 2).
- R6: A frame lasts two sample periods in dual-lane mode and one sample period otherwise. `frm_clk` is 1 in the first half of each frame and 0 in the second half.
- R7: `bit_clk` inverts on every clock and is 1 in the first bit cycle of every frame.
- R8: Dual-lane: `lane_a[0]` carries the upper half of the channel A word and `lane_a[1]` the lower half, each MSB first. `lane_b[1:0]` carry channel B in the same way.
- R9: Single-lane: channel A is sent MSB first on `lane_a[0]` and channel B on `lane_b[0]`. `lane_a[1]` and `lane_b[1]` stay 0.
- R10: Shared-lane: `lane_a[0]` carries the whole channel A word and then the whole channel B word, each MSB first. All other lanes stay 0.
- R11: A configuration change made at any time takes effect at the first frame boundary after it. Every frame is sent entirely in one configuration.
- R12: `cfg_bad` is 1, combinationally, when `cfg_lane` = 3 or when the requested lane bits per sample exceed MAX_LANE_BITS (default 32). Such a request is never adopted, and the previous configuration stays in effect.
- R13: `smp_take` is 1 in the last bit cycle of each sample period. The sample inputs present at the clock edge that ends that cycle are the ones sent in the next sample period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_res | input | 2 | Requested resolution code (0:14, 1:16, 2:18, 3:20 bits) |
| cfg_lane | input | 2 | Requested lane arrangement (0 dual, 1 single, 2 shared, 3 reserved) |
| cfg_avg | input | 1 | Selects the 20-bit averaged source |
| smp_a | input | IN_W | Channel A sample, 16-bit path |
| smp_b | input | IN_W | Channel B sample, 16-bit path |
| avg_a | input | OUT_W | Channel A sample, averaged path |
| avg_b | input | OUT_W | Channel B sample, averaged path |
| smp_take | output | 1 | Samples are captured at the end of this cycle |
| cfg_bad | output | 1 | Requested configuration is invalid |
| frm_clk | output | 1 | Frame marker |
| bit_clk | output | 1 | Bit clock, half the lane bit rate |
| lane_a | output | 2 | Channel A lanes (shared-lane traffic on bit 0) |
| lane_b | output | 2 | Channel B lanes |

## Verification
On every cycle, the bound assertions check these properties:
- the bit clock alternates;
- a new frame starts with the frame marker and the bit clock high;
- `smp_take` is asserted at the end of each frame;
- the active configuration moves only at a frame end, and never to a rejected request;
- lanes that are idle in the current arrangement stay low.

Only the bench's scenarios can show that the deserialized words match the truncation, zero padding and averaged data for every resolution, lane arrangement and source. They also show that the sample period and the frame marker have the right length for each combination. Finally, they show that changes made in the middle of a sample or of a dual-lane frame are deferred to the correct boundary.

// File: rtl/smp_ser_pkg.sv
package smp_ser_pkg;

   typedef enum logic [1:0] {
      LN_DUAL   = 2'd0,
      LN_SINGLE = 2'd1,
      LN_SHARED = 2'd2,
      LN_RSVD   = 2'd3
   } lane_mode_e;

   typedef struct packed {
      logic [1:0] res;
      lane_mode_e lane;
      logic       avg;
   } ser_cfg_t;

   localparam ser_cfg_t CFG_DEFAULT = '{res: 2'd2, lane: LN_DUAL, avg: 1'b0};

   // resolution in bits for a resolution code
   function automatic int res_bits(input logic [1:0] code);
      return 14 + 2 * int'(code);
   endfunction

   // bits sent on each lane per sample
   function automatic int lane_bits(input logic [1:0] code, input lane_mode_e lane);
      case (lane)
         LN_DUAL:   return res_bits(code) / 2;
         LN_SINGLE: return res_bits(code);
         LN_SHARED: return 2 * res_bits(code);
         default:   return 0;
      endcase
   endfunction

   // clocks per frame
   function automatic int frame_bits(input logic [1:0] code, input lane_mode_e lane);
      return (lane == LN_SHARED) ? 2 * res_bits(code) : res_bits(code);
   endfunction

endpackage

// File: rtl/ser_cfg_ctrl.sv
module ser_cfg_ctrl
   import smp_ser_pkg::*;
#(
   parameter int MAX_LANE_BITS = 32
) (
   input  logic     clk,
   input  logic     rst_n,
   input  ser_cfg_t req_cfg,
   input  logic     adopt,
   output ser_cfg_t act_cfg,
   output ser_cfg_t nxt_cfg,
   output logic     req_bad
);

   always_comb begin
      req_bad = (req_cfg.lane == LN_RSVD) ||
                (lane_bits(req_cfg.res, req_cfg.lane) > MAX_LANE_BITS);
      nxt_cfg = (adopt && !req_bad) ? req_cfg : act_cfg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) act_cfg <= CFG_DEFAULT;
      else        act_cfg <= nxt_cfg;
   end

endmodule

// File: rtl/ser_frame_cnt.sv
module ser_frame_cnt
   import smp_ser_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       act_res,
   input  lane_mode_e       act_lane,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] pos,
   output logic             samp_last,
   output logic             frame_last,
   output logic             frame_hi,
   output logic             adopt
);

   localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(frame_bits(CFG_DEFAULT.res, CFG_DEFAULT.lane) - 1);

   logic [CNT_W-1:0] flen, slen;
   logic             first_q;

   always_comb begin
      flen       = CNT_W'(frame_bits(act_res, act_lane));
      slen       = CNT_W'(lane_bits(act_res, act_lane));
      frame_last = (cnt == flen - 1'b1);
      samp_last  = frame_last || ((act_lane == LN_DUAL) && (cnt == slen - 1'b1));
      pos        = ((act_lane == LN_DUAL) && (cnt >= slen)) ? cnt - slen : cnt;
      frame_hi   = (cnt < (flen >> 1));
      adopt      = frame_last && !first_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= CNT_RST;
         first_q <= 1'b1;
      end else begin
         cnt     <= frame_last ? '0 : cnt + 1'b1;
         first_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ser_word_fmt.sv
module ser_word_fmt #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 20
) (
   input  logic [IN_W-1:0]  smp_in,
   input  logic [OUT_W-1:0] avg_in,
   input  logic             avg_en,
   input  logic [1:0]       res,
   output logic [OUT_W-1:0] word
);

   logic [OUT_W-1:0] src;
   int               keep;

   always_comb begin
      src  = avg_en ? avg_in : (OUT_W'(smp_in) << (OUT_W - IN_W));
      keep = smp_ser_pkg::res_bits(res);
      for (int i = 0; i < OUT_W; i++)
         word[i] = (i >= OUT_W - keep) ? src[i] : 1'b0;
   end

endmodule

// File: rtl/ser_lane_mux.sv
module ser_lane_mux
   import smp_ser_pkg::*;
#(
   parameter int OUT_W = 20,
   parameter int CNT_W = 6
) (
   input  logic [1:0]       act_res,
   input  lane_mode_e       act_lane,
   input  logic [CNT_W-1:0] pos,
   input  logic [OUT_W-1:0] word_a,
   input  logic [OUT_W-1:0] word_b,
   output logic [1:0]       lane_a,
   output logic [1:0]       lane_b
);

   logic [CNT_W-1:0] rb, hb;
   logic [OUT_W-1:0] sa_hi, sa_lo, sb_hi, sb_lo, sh;

   always_comb begin
      rb     = CNT_W'(res_bits(act_res));
      hb     = rb >> 1;
      sa_hi  = word_a << pos;
      sa_lo  = word_a << (pos + hb);
      sb_hi  = word_b << pos;
      sb_lo  = word_b << (pos + hb);
      sh     = (pos < rb) ? (word_a << pos) : (word_b << (pos - rb));
      lane_a = '0;
      lane_b = '0;
      case (act_lane)
         LN_DUAL: begin
            lane_a = {sa_lo[OUT_W-1], sa_hi[OUT_W-1]};
            lane_b = {sb_lo[OUT_W-1], sb_hi[OUT_W-1]};
         end
         LN_SINGLE: begin
            lane_a = {1'b0, sa_hi[OUT_W-1]};
            lane_b = {1'b0, sb_hi[OUT_W-1]};
         end
         LN_SHARED: lane_a = {1'b0, sh[OUT_W-1]};
         default: ;
      endcase
   end

endmodule

// File: rtl/smp_lane_serializer.sv
module smp_lane_serializer
   import smp_ser_pkg::*;
#(
   parameter int IN_W          = 16,
   parameter int OUT_W         = 20,
   parameter int MAX_LANE_BITS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_res,
   input  logic [1:0]       cfg_lane,
   input  logic             cfg_avg,
   input  logic [IN_W-1:0]  smp_a,
   input  logic [IN_W-1:0]  smp_b,
   input  logic [OUT_W-1:0] avg_a,
   input  logic [OUT_W-1:0] avg_b,
   output logic             smp_take,
   output logic             cfg_bad,
   output logic             frm_clk,
   output logic             bit_clk,
   output logic [1:0]       lane_a,
   output logic [1:0]       lane_b
);

   localparam int CNT_W = $clog2(2 * OUT_W);
   localparam int N_CH  = 2;

   // elaboration-time parameter checks
   if (OUT_W != 20) begin : g_bad_out_w
      $error("OUT_W must be 20: resolution codes span 14 to 20 bits");
   end
   if (IN_W < 14 || IN_W >= OUT_W) begin : g_bad_in_w
      $error("IN_W must lie in 14 .. OUT_W-1");
   end
   if (MAX_LANE_BITS < 9 || MAX_LANE_BITS > 2 * OUT_W) begin : g_bad_max
      $error("MAX_LANE_BITS must admit the default dual-lane mode");
   end

   ser_cfg_t         req_cfg, act_cfg, nxt_cfg;
   logic             req_bad, adopt, frame_last, samp_last, frame_hi;
   logic [CNT_W-1:0] cnt, pos;
   logic [IN_W-1:0]  smp_in [N_CH];
   logic [OUT_W-1:0] avg_in [N_CH];
   logic [OUT_W-1:0] fmt_w  [N_CH];
   logic [OUT_W-1:0] word_q [N_CH];

   assign req_cfg   = '{res: cfg_res, lane: lane_mode_e'(cfg_lane), avg: cfg_avg};
   assign smp_in[0] = smp_a;
   assign smp_in[1] = smp_b;
   assign avg_in[0] = avg_a;
   assign avg_in[1] = avg_b;

   ser_cfg_ctrl #(.MAX_LANE_BITS(MAX_LANE_BITS)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_cfg (req_cfg),
      .adopt   (adopt),
      .act_cfg (act_cfg),
      .nxt_cfg (nxt_cfg),
      .req_bad (req_bad)
   );

   ser_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_res    (act_cfg.res),
      .act_lane   (act_cfg.lane),
      .cnt        (cnt),
      .pos        (pos),
      .samp_last  (samp_last),
      .frame_last (frame_last),
      .frame_hi   (frame_hi),
      .adopt      (adopt)
   );

   // per-channel formatting and capture, using the configuration of the next period
   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      ser_word_fmt #(.IN_W(IN_W), .OUT_W(OUT_W)) u_fmt (
         .smp_in (smp_in[ch]),
         .avg_in (avg_in[ch]),
         .avg_en (nxt_cfg.avg),
         .res    (nxt_cfg.res),
         .word   (fmt_w[ch])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)         word_q[ch] <= '0;
         else if (samp_last) word_q[ch] <= fmt_w[ch];
      end
   end

   ser_lane_mux #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_mux (
      .act_res  (act_cfg.res),
      .act_lane (act_cfg.lane),
      .pos      (pos),
      .word_a   (word_q[0]),
      .word_b   (word_q[1]),
      .lane_a   (lane_a),
      .lane_b   (lane_b)
   );

   assign smp_take = samp_last;
   assign cfg_bad  = req_bad;
   assign frm_clk  = frame_hi;
   assign bit_clk  = ~cnt[0];

endmodule

// File: rtl/ser_chk.sv
module ser_chk
   import smp_ser_pkg::*;
#(
   parameter int MAX_LANE_BITS = 32
) (
   input logic       clk,
   input logic       rst_n,
   input ser_cfg_t   act_cfg,
   input logic       frame_last,
   input logic       smp_take,
   input logic       cfg_bad,
   input logic       frm_clk,
   input logic       bit_clk,
   input logic [1:0] lane_a,
   input logic [1:0] lane_b
);

   AST_BCLK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (bit_clk != $past(bit_clk)));                                // R7

   AST_FRAME_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      frame_last |=> (frm_clk && bit_clk));                                  // R6

   AST_TAKE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      frame_last |-> smp_take);                                              // R13

   AST_CFG_HOLDS_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_last |=> $stable(act_cfg));                                     // R11

   AST_BAD_NOT_ADOPTED: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_last && cfg_bad) |=> $stable(act_cfg));                         // R12

   AST_ACTIVE_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cfg.lane != LN_RSVD) && (lane_bits(act_cfg.res, act_cfg.lane) <= MAX_LANE_BITS)); // R12

   AST_SPARE_LANES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cfg.lane != LN_DUAL) |-> (!lane_a[1] && !lane_b[1]));             // R9

   AST_SHARED_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cfg.lane == LN_SHARED) |-> (lane_b == 2'b00));                    // R10

endmodule

bind smp_lane_serializer ser_chk #(.MAX_LANE_BITS(MAX_LANE_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .act_cfg    (act_cfg),
   .frame_last (frame_last),
   .smp_take   (smp_take),
   .cfg_bad    (cfg_bad),
   .frm_clk    (frm_clk),
   .bit_clk    (bit_clk),
   .lane_a     (lane_a),
   .lane_b     (lane_b)
);

// File: tb/smp_lane_serializer_tb_top.sv
module smp_lane_serializer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int MAXB       = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_res = 2'd1, cfg_lane = 2'd1;
   logic        cfg_avg = 1'b0;
   logic [15:0] smp_a = '0, smp_b = '0;
   logic [19:0] avg_a = '0, avg_b = '0;
   logic        smp_take, cfg_bad, frm_clk, bit_clk;
   logic [1:0]  lane_a, lane_b;

   always #(CLK_PERIOD / 2) clk = ~clk;

   smp_lane_serializer #(.MAX_LANE_BITS(MAXB)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_res(cfg_res), .cfg_lane(cfg_lane), .cfg_avg(cfg_avg),
      .smp_a(smp_a), .smp_b(smp_b), .avg_a(avg_a), .avg_b(avg_b),
      .smp_take(smp_take), .cfg_bad(cfg_bad), .frm_clk(frm_clk), .bit_clk(bit_clk),
      .lane_a(lane_a), .lane_b(lane_b)
   );

   typedef struct packed {
      logic [1:0]  res;
      logic [1:0]  lane;
      logic        avg;
      logic [19:0] wa;
      logic [19:0] wb;
   } item_t;

   item_t sbq[$];
   int    n_checks = 0, n_fail = 0;
   bit    drv_done = 0, finished = 0;

   // ---------------- reference model, built from the requirements ----------------
   function automatic int rbits(input int code); return 14 + 2 * code; endfunction
   function automatic int lbits(input int code, input int lane);
      if (lane == 0) return rbits(code) / 2;
      if (lane == 1) return rbits(code);
      if (lane == 2) return 2 * rbits(code);
      return 0;
   endfunction
   function automatic int fbits(input int code, input int lane);
      return (lane == 2) ? 2 * rbits(code) : rbits(code);
   endfunction
   function automatic logic [19:0] fmt(input int code, input bit av, input logic [15:0] s, input logic [19:0] a);
      logic [19:0] src, w;
      src = av ? a : {s, 4'b0000};
      for (int i = 0; i < 20; i++) w[i] = (i >= 20 - rbits(code)) ? src[i] : 1'b0;
      return w;
   endfunction

   int m_cnt, m_res, m_lane;
   bit m_avg, m_first;

   function automatic bit req_ok();
      return (cfg_lane != 2'd3) && (lbits(int'(cfg_res), int'(cfg_lane)) <= MAXB);
   endfunction
   function automatic bit m_frame_last(); return m_cnt == fbits(m_res, m_lane) - 1; endfunction
   function automatic bit m_take();
      return m_frame_last() || (m_lane == 0 && m_cnt == lbits(m_res, m_lane) - 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 17; m_res = 2; m_lane = 0; m_avg = 0; m_first = 1;
      end else begin
         if (m_frame_last()) begin
            if (!m_first && req_ok()) begin
               m_res = int'(cfg_res); m_lane = int'(cfg_lane); m_avg = cfg_avg;
            end
            m_cnt = 0;
         end else m_cnt++;
         m_first = 0;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- driver: pushes expected items at each capture ----------------
   task automatic push_one();
      item_t it;
      int    nres, nlane;
      bit    navg;
      smp_a = 16'($urandom); smp_b = 16'($urandom);
      avg_a = 20'($urandom); avg_b = 20'($urandom);
      if ($urandom_range(0, 7) == 0) begin smp_a = '1; avg_b = '1; end
      nres = m_res; nlane = m_lane; navg = m_avg;
      if (m_frame_last() && !m_first && req_ok()) begin
         nres = int'(cfg_res); nlane = int'(cfg_lane); navg = cfg_avg;
      end
      it.res  = 2'(nres);
      it.lane = 2'(nlane);
      it.avg  = navg;
      it.wa   = fmt(nres, navg, smp_a, avg_a);
      it.wb   = fmt(nres, navg, smp_b, avg_b);
      sbq.push_back(it);
   endtask

   task automatic send(input int n, input int res, input int lane, input bit av);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         while (!m_take()) @(negedge clk);
         if (k == 0) begin
            cfg_res = 2'(res); cfg_lane = 2'(lane); cfg_avg = av;
            #1;
            check(cfg_bad == !req_ok(), $sformatf("R12 cfg_bad res=%0d lane=%0d", res, lane),
                  32'(cfg_bad), 32'(!req_ok()));
         end
         push_one();
      end
   endtask

   task automatic change_mid(input int res, input int lane, input bit av);
      @(negedge clk);
      while (m_take()) @(negedge clk);
      cfg_res = 2'(res); cfg_lane = 2'(lane); cfg_avg = av;
   endtask

   // ---------------- monitor: pops and compares per sample ----------------
   item_t       cur;
   bit          have = 0, bad = 0;
   int          idx = 0;
   logic [6:0]  bgot, bexp;
   int          bpos;

   function automatic logic [3:0] exp_lanes(input item_t it, input int p);
      int         rb;
      logic [1:0] la, lb;
      rb = rbits(int'(it.res));
      la = 0; lb = 0;
      case (int'(it.lane))
         0: begin
            la = {it.wa[19 - rb / 2 - p], it.wa[19 - p]};
            lb = {it.wb[19 - rb / 2 - p], it.wb[19 - p]};
         end
         1: begin la[0] = it.wa[19 - p]; lb[0] = it.wb[19 - p]; end
         default: la[0] = (p < rb) ? it.wa[19 - p] : it.wb[19 - (p - rb)];
      endcase
      return {lb, la};
   endfunction

   function automatic string tags(input item_t it, input int i);
      string s;
      s = "R5 R6 R7 R11 R13";
      case (int'(it.lane)) 0: s = {s, " R8"}; 1: s = {s, " R9"}; default: s = {s, " R10"}; endcase
      if (it.avg) s = {s, " R4"};
      else if (it.res == 2'd0) s = {s, " R2"};
      else s = {s, " R3"};
      if (i <= 2) s = {s, " R1"};
      return s;
   endfunction

   always @(negedge clk) begin
      if (rst_n && !m_first) begin
         int P, F, p;
         logic [6:0] got, exp;
         P = lbits(m_res, m_lane);
         F = fbits(m_res, m_lane);
         p = (m_lane == 0 && m_cnt >= P) ? m_cnt - P : m_cnt;
         if (p == 0) begin
            if (sbq.size() > 0) begin
               cur = sbq.pop_front(); have = 1; bad = 0; idx++;
            end else begin
               have = 0;
               if (!drv_done) check(1'b0, "R13 no expected sample queued", 0, 1);
            end
         end
         if (have) begin
            got = {lane_b, lane_a, frm_clk, bit_clk, smp_take};
            exp = {exp_lanes(cur, p), 1'(m_cnt < F / 2), ~1'(m_cnt % 2), m_take()};
            if (got !== exp && !bad) begin bad = 1; bgot = got; bexp = exp; bpos = p; end
            if (p == P - 1) begin
               check(!bad, $sformatf("%s sample %0d pos %0d {lanes_b,lanes_a,frm,bclk,take}",
                     tags(cur, idx), idx, bpos), 32'(bgot), 32'(bexp));
               have = 0;
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(smp_take == 1'b1, "R1 R13 smp_take in reset", 32'(smp_take), 1);
      check(frm_clk == 1'b0, "R1 frm_clk in reset", 32'(frm_clk), 0);
      check(bit_clk == 1'b0, "R1 bit_clk in reset", 32'(bit_clk), 0);
      check({lane_b, lane_a} == 4'b0, "R1 lanes in reset", 32'({lane_b, lane_a}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      push_one();                 // first capture uses the default configuration
      send(4, 0, 0, 0);
      for (int av = 0; av < 2; av++)
         for (int ln = 0; ln < 3; ln++)
            for (int rs = 0; rs < 4; rs++)
               send(5, rs, ln, bit'(av));
      send(3, 1, 3, 0);           // reserved lane code, rejected
      change_mid(3, 1, 1);        // change inside a sample
      send(4, 3, 1, 1);
      change_mid(0, 0, 0);
      send(5, 0, 0, 0);
      change_mid(2, 2, 0);        // invalid shared 18-bit request mid-sample
      send(4, 2, 2, 0);
      send(4, 1, 2, 1);
      drv_done = 1;
      repeat (100) @(negedge clk);
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule